// File: doc/BRIEF.md
# Page Replacement Victim Selector

This block keeps track of which virtual page sits in each of a small, fixed set of physical frames. Every reference carries a page number. The block answers it with a hit, which names the frame that already holds the page, or with a fault, which names the frame the page is to be loaded into. When a free frame is left, a fault takes it. When every frame is occupied, a replacement policy picks the frame to overwrite. The policy is chosen per reference by a mode input: oldest arrival, least recent use, smallest usage count, or largest usage count. Where usage counts are equal, the frame whose page arrived earliest is chosen. The usage counts can be halved after a programmable number of references, so that early bursts of activity fade out.

The block only makes the decision and updates its own bookkeeping. Moving the page data from backing store is left to the surrounding logic. A running count of all faults, including the fills of free frames, is provided so that fault rates can be compared across policies.

Top module: `pgrep_selector`

## Requirements
- R1: A reference to a page that is resident in a frame reports a hit with that frame's index, loads nothing, and leaves the fault count unchanged.
- R2: A fault while any frame is empty reports the lowest-numbered empty frame with the eviction flag low. The eviction flag is high only on faults that overwrite a resident page.
- R3: With mode 0 (arrival order), a fault on a full set evicts the resident page that was loaded earliest.
- R4: With mode 1 (recency), a fault on a full set evicts the resident page whose most recent reference, either the hit or the load, is oldest.
- R5: With mode 2 (low count), a fault on a full set evicts the page with the smallest usage count. A tie goes to the page loaded earliest.
- R6: With mode 3 (high count), a fault on a full set evicts the page with the largest usage count. A tie goes to the page loaded earliest.
- R7: A freshly loaded page gets a usage count of 1. Each hit adds 1 to the count, which saturates at 2^CNT_W-1.
- R8: When `age_interval` is N (nonzero), every N-th reference since reset, or since the last halving, shifts every usage count right by one bit after that reference's own update. An interval of 0 disables halving and clears the interval counter.
- R9: `repl_count` increases by one, wrapping, for each fault, including fills of empty frames. It holds its value otherwise.
- R10: After reset all frames are empty, `repl_count` is 0 and `rsp_valid` is low.
- R11: Each reference produces exactly one response, on the clock after `ref_valid`, with exactly one of `rsp_hit` and `rsp_fault` high. `rsp_valid` is low on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A page reference is presented this cycle |
| ref_page | input | PAGE_W | Virtual page number of the reference |
| mode | input | 2 | Replacement policy: 0 arrival, 1 recency, 2 low count, 3 high count |
| age_interval | input | AGE_W | References between count halvings; 0 disables |
| rsp_valid | output | 1 | Response for the previous cycle's reference |
| rsp_hit | output | 1 | The page was resident |
| rsp_fault | output | 1 | The page was not resident |
| rsp_evict | output | 1 | The fault overwrote a resident page |
| rsp_frame | output | FRAME_W | Hit frame, or the frame that receives the page |
| repl_count | output | COUNT_W | Running fault count |

## Verification
A wrong arrival rank, recency rank or usage count does not show at once. It shows only on the next fault against a full set, where a different frame is reported, or later still on a hit to a page that should already have been evicted. For that reason, every reference in a long run is compared against a reference model, with the mode and the page mix varied, so that a state error is caught at the first decision it changes. A wrong tag or valid bit shows on the very next reference to that page as a swapped hit and fault, and from then on as drift in `repl_count`. Directed sequences set up usage counts that are equal only because of saturation or halving, so that those two rules decide which frame is reported.

// File: rtl/pgrep_pkg.sv
package pgrep_pkg;

    typedef enum logic [1:0] {
        POL_FIFO = 2'd0,
        POL_LRU  = 2'd1,
        POL_LFU  = 2'd2,
        POL_MFU  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ACT_HIT   = 2'd0,
        ACT_FILL  = 2'd1,
        ACT_EVICT = 2'd2
    } action_e;

    typedef struct packed {
        logic hit;
        logic fault;
        logic evict;
    } rsp_flags_t;

endpackage

// File: rtl/pgrep_lookup.sv
module pgrep_lookup #(
    parameter int FRAMES = 4,
    parameter int PAGE_W = 8,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0]  valid,
    input  logic [PAGE_W-1:0]  tags [FRAMES],
    input  logic [PAGE_W-1:0]  page,
    output logic               hit,
    output logic [FRAME_W-1:0] hit_idx,
    output logic               has_empty,
    output logic [FRAME_W-1:0] empty_idx
);
    logic [FRAMES-1:0] match;

    for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == page);
    end

    // lowest index wins in both searches
    always_comb begin
        hit       = |match;
        has_empty = ~&valid;
        hit_idx   = '0;
        empty_idx = '0;
        for (int i = FRAMES - 1; i >= 0; i--) begin
            if (match[i])  hit_idx   = FRAME_W'(i);
            if (!valid[i]) empty_idx = FRAME_W'(i);
        end
    end
endmodule

// File: rtl/pgrep_victim.sv
module pgrep_victim
    import pgrep_pkg::*;
#(
    parameter int FRAMES = 4,
    parameter int CNT_W  = 4,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input  policy_e            mode,
    input  logic [FRAME_W-1:0] arr_rank [FRAMES],
    input  logic [FRAME_W-1:0] use_rank [FRAMES],
    input  logic [CNT_W-1:0]   cnt      [FRAMES],
    output logic [FRAME_W-1:0] victim
);
    localparam int KEY_W = CNT_W + FRAME_W;

    // every policy reduces to "smallest key wins"; ranks are distinct
    // among resident frames, so the key never ties on a full set
    logic [KEY_W-1:0] key [FRAMES];

    for (genvar g = 0; g < FRAMES; g++) begin : g_key
        always_comb begin
            unique case (mode)
                POL_FIFO: key[g] = {{CNT_W{1'b0}}, arr_rank[g]};
                POL_LRU:  key[g] = {{CNT_W{1'b0}}, use_rank[g]};
                POL_LFU:  key[g] = {cnt[g], arr_rank[g]};
                default:  key[g] = {~cnt[g], arr_rank[g]};
            endcase
        end
    end

    always_comb begin
        logic [KEY_W-1:0] best;
        best   = key[0];
        victim = '0;
        for (int i = 1; i < FRAMES; i++) begin
            if (key[i] < best) begin
                best   = key[i];
                victim = FRAME_W'(i);
            end
        end
    end
endmodule

// File: rtl/pgrep_age_timer.sv
module pgrep_age_timer #(
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [AGE_W-1:0] interval,
    output logic             age_now
);
    logic [AGE_W-1:0] seen_q;
    logic [AGE_W:0]   seen_inc;

    assign seen_inc = {1'b0, seen_q} + 1'b1;
    assign age_now  = step && (interval != '0) && (seen_inc >= {1'b0, interval});

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (step) begin
            if (interval == '0 || age_now) seen_q <= '0;
            else                           seen_q <= seen_inc[AGE_W-1:0];
        end
    end
endmodule

// File: rtl/pgrep_selector.sv
module pgrep_selector
    import pgrep_pkg::*;
#(
    parameter int FRAMES  = 4,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 4,
    parameter int AGE_W   = 8,
    parameter int COUNT_W = 16,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_valid,
    input  logic [PAGE_W-1:0]  ref_page,
    input  logic [1:0]         mode,
    input  logic [AGE_W-1:0]   age_interval,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic               rsp_evict,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic [COUNT_W-1:0] repl_count
);
    localparam logic [CNT_W-1:0]   CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [FRAME_W-1:0] RANK_TOP = FRAME_W'(FRAMES - 1);

    // per-frame state
    logic [FRAMES-1:0]  valid_q, valid_d;
    logic [PAGE_W-1:0]  tag_q [FRAMES];
    logic [PAGE_W-1:0]  tag_d [FRAMES];
    logic [FRAME_W-1:0] arr_q [FRAMES];
    logic [FRAME_W-1:0] arr_d [FRAMES];
    logic [FRAME_W-1:0] use_q [FRAMES];
    logic [FRAME_W-1:0] use_d [FRAMES];
    logic [CNT_W-1:0]   cnt_q [FRAMES];
    logic [CNT_W-1:0]   cnt_d [FRAMES];

    logic               lk_hit, lk_empty, age_now;
    logic [FRAME_W-1:0] lk_hit_idx, lk_empty_idx, vic_idx, sel_idx;
    logic [FRAME_W:0]   n_resident;
    action_e            act;
    rsp_flags_t         flags;
    policy_e            pol;

    assign pol = policy_e'(mode);

    pgrep_lookup #(.FRAMES(FRAMES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_lookup (
        .valid     (valid_q),
        .tags      (tag_q),
        .page      (ref_page),
        .hit       (lk_hit),
        .hit_idx   (lk_hit_idx),
        .has_empty (lk_empty),
        .empty_idx (lk_empty_idx)
    );

    pgrep_victim #(.FRAMES(FRAMES), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_victim (
        .mode     (pol),
        .arr_rank (arr_q),
        .use_rank (use_q),
        .cnt      (cnt_q),
        .victim   (vic_idx)
    );

    pgrep_age_timer #(.AGE_W(AGE_W)) u_age (
        .clk      (clk),
        .rst      (rst),
        .step     (ref_valid),
        .interval (age_interval),
        .age_now  (age_now)
    );

    assign n_resident = (FRAME_W + 1)'($countones(valid_q));

    always_comb begin
        if (lk_hit) begin
            act = ACT_HIT;   sel_idx = lk_hit_idx;
        end else if (lk_empty) begin
            act = ACT_FILL;  sel_idx = lk_empty_idx;
        end else begin
            act = ACT_EVICT; sel_idx = vic_idx;
        end
        flags.hit   = (act == ACT_HIT);
        flags.fault = (act != ACT_HIT);
        flags.evict = (act == ACT_EVICT);
    end

    // ranks: 0 is oldest, the highest live rank is the newest resident
    always_comb begin
        valid_d = valid_q;
        for (int j = 0; j < FRAMES; j++) begin
            tag_d[j] = tag_q[j];
            arr_d[j] = arr_q[j];
            use_d[j] = use_q[j];
            cnt_d[j] = cnt_q[j];
        end
        if (ref_valid) begin
            unique case (act)
                ACT_HIT: begin
                    for (int j = 0; j < FRAMES; j++)
                        if (valid_q[j] && use_q[j] > use_q[sel_idx])
                            use_d[j] = use_q[j] - 1'b1;
                    use_d[sel_idx] = FRAME_W'(n_resident - 1'b1);
                    if (cnt_q[sel_idx] != CNT_MAX)
                        cnt_d[sel_idx] = cnt_q[sel_idx] + 1'b1;
                end
                ACT_FILL: begin
                    valid_d[sel_idx] = 1'b1;
                    tag_d[sel_idx]   = ref_page;
                    arr_d[sel_idx]   = FRAME_W'(n_resident);
                    use_d[sel_idx]   = FRAME_W'(n_resident);
                    cnt_d[sel_idx]   = CNT_W'(1);
                end
                default: begin
                    for (int j = 0; j < FRAMES; j++) begin
                        if (arr_q[j] > arr_q[sel_idx]) arr_d[j] = arr_q[j] - 1'b1;
                        if (use_q[j] > use_q[sel_idx]) use_d[j] = use_q[j] - 1'b1;
                    end
                    tag_d[sel_idx] = ref_page;
                    arr_d[sel_idx] = RANK_TOP;
                    use_d[sel_idx] = RANK_TOP;
                    cnt_d[sel_idx] = CNT_W'(1);
                end
            endcase
            if (age_now)
                for (int j = 0; j < FRAMES; j++)
                    cnt_d[j] = cnt_d[j] >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int j = 0; j < FRAMES; j++) begin
                tag_q[j] <= '0;
                arr_q[j] <= '0;
                use_q[j] <= '0;
                cnt_q[j] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            for (int j = 0; j < FRAMES; j++) begin
                tag_q[j] <= tag_d[j];
                arr_q[j] <= arr_d[j];
                use_q[j] <= use_d[j];
                cnt_q[j] <= cnt_d[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_evict  <= 1'b0;
            rsp_frame  <= '0;
            repl_count <= '0;
        end else begin
            rsp_valid <= ref_valid;
            if (ref_valid) begin
                rsp_hit   <= flags.hit;
                rsp_fault <= flags.fault;
                rsp_evict <= flags.evict;
                rsp_frame <= sel_idx;
                if (flags.fault) repl_count <= repl_count + 1'b1;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_fault <= 1'b0;
                rsp_evict <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgrep_selector_chk.sv
module pgrep_selector_chk #(
    parameter int FRAMES  = 4,
    parameter int COUNT_W = 16,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input logic               clk,
    input logic               rst,
    input logic               ref_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic               rsp_evict,
    input logic [FRAME_W-1:0] rsp_frame,
    input logic [COUNT_W-1:0] repl_count
);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_fault}) == 1);

    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> rsp_valid);

    p_no_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> !rsp_valid);

    p_fault_counts_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> repl_count == $past(repl_count) + COUNT_W'(1));

    p_hit_keeps_count_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> $stable(repl_count));

    p_idle_keeps_count_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(repl_count));

    p_evict_is_fault_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_evict |-> (rsp_valid && rsp_fault));

    p_frame_range_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> int'(rsp_frame) < FRAMES);
endmodule

bind pgrep_selector pgrep_selector_chk #(
    .FRAMES(FRAMES), .COUNT_W(COUNT_W), .FRAME_W(FRAME_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_valid  (ref_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_evict  (rsp_evict),
    .rsp_frame  (rsp_frame),
    .repl_count (repl_count)
);

// File: tb/test_pgrep_selector.sv
module test_pgrep_selector;
    localparam int CLK_PERIOD = 10;
    localparam int F     = 4;
    localparam int PW    = 8;
    localparam int CW    = 4;
    localparam int AW    = 8;
    localparam int KW    = 16;
    localparam int FW    = 2;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_valid = 1'b0;
    logic [PW-1:0] ref_page = '0;
    logic [1:0]    mode = 2'd0;
    logic [AW-1:0] age_interval = '0;
    logic          rsp_valid, rsp_hit, rsp_fault, rsp_evict;
    logic [FW-1:0] rsp_frame;
    logic [KW-1:0] repl_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pgrep_selector #(.FRAMES(F), .PAGE_W(PW), .CNT_W(CW), .AGE_W(AW), .COUNT_W(KW)) i_pgrep_selector (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_page(ref_page), .mode(mode),
        .age_interval(age_interval), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_evict(rsp_evict), .rsp_frame(rsp_frame),
        .repl_count(repl_count)
    );

    // reference model, timestamp based
    bit m_valid [F];
    int m_tag [F], m_arr [F], m_use [F], m_cnt [F];
    int m_stamp, m_agecnt, m_faults;

    task automatic model_clear();
        for (int i = 0; i < F; i++) begin
            m_valid[i] = 0; m_tag[i] = 0; m_arr[i] = 0; m_use[i] = 0; m_cnt[i] = 0;
        end
        m_stamp = 0; m_agecnt = 0; m_faults = 0;
    endtask

    function automatic bit better(int a, int b, int pol);
        case (pol)
            0: return m_arr[a] < m_arr[b];
            1: return m_use[a] < m_use[b];
            2: return (m_cnt[a] < m_cnt[b]) || (m_cnt[a] == m_cnt[b] && m_arr[a] < m_arr[b]);
            default: return (m_cnt[a] > m_cnt[b]) || (m_cnt[a] == m_cnt[b] && m_arr[a] < m_arr[b]);
        endcase
    endfunction

    task automatic model_step(input int page, input int pol, input int interval,
                              output bit hit, output bit evict, output int frame);
        int empty;
        hit = 0; evict = 0; frame = -1; empty = -1;
        for (int i = 0; i < F; i++)
            if (m_valid[i] && m_tag[i] == page && frame < 0) frame = i;
        if (frame >= 0) begin
            hit = 1;
            m_use[frame] = m_stamp;
            if (m_cnt[frame] < CMAX) m_cnt[frame]++;
        end else begin
            m_faults++;
            for (int i = F - 1; i >= 0; i--) if (!m_valid[i]) empty = i;
            if (empty >= 0) frame = empty;
            else begin
                evict = 1; frame = 0;
                for (int i = 1; i < F; i++) if (better(i, frame, pol)) frame = i;
            end
            m_valid[frame] = 1; m_tag[frame] = page;
            m_arr[frame] = m_stamp; m_use[frame] = m_stamp; m_cnt[frame] = 1;
        end
        m_stamp++;
        if (interval == 0) m_agecnt = 0;
        else if (m_agecnt + 1 >= interval) begin
            for (int i = 0; i < F; i++) m_cnt[i] = m_cnt[i] >> 1;
            m_agecnt = 0;
        end else m_agecnt++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with the response checked
    task automatic do_ref(input int page, input int pol);
        bit eh, ee; int ef; string req;
        ref_valid = 1'b1; ref_page = PW'(page); mode = 2'(pol);
        model_step(page, pol, int'(age_interval), eh, ee, ef);
        @(negedge clk);
        ref_valid = 1'b0;
        if (eh) req = "R1";
        else if (!ee) req = "R2";
        else case (pol) 0: req = "R3"; 1: req = "R4"; 2: req = "R5"; default: req = "R6"; endcase
        check(rsp_valid && rsp_hit == eh && rsp_fault == !eh && rsp_evict == ee && int'(rsp_frame) == ef,
              {req, "/R11 response {valid,hit,evict,frame}"},
              {rsp_valid, rsp_hit, rsp_evict, 4'(rsp_frame)}, {1'b1, eh, ee, 4'(ef)});
        check(int'(repl_count) == (m_faults % (1 << KW)), "R9 fault count", int'(repl_count), m_faults);
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic run_string(input int pol, input int exp_faults, input string req);
        int seq [12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
        int base;
        do_reset();
        base = int'(repl_count);
        foreach (seq[k]) do_ref(seq[k], pol);
        check(int'(repl_count) - base == exp_faults, req, int'(repl_count) - base, exp_faults);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(rsp_valid == 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);
        check(repl_count == '0, "R10 repl_count after reset", int'(repl_count), 0);
        // R2: first reference fills frame 0
        do_ref(7, 0);
        check(rsp_frame == 0 && !rsp_evict, "R2 first fill frame", int'(rsp_frame), 0);
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_fault == 1'b0, "R11 idle cycle", rsp_valid, 0);

        // classic reference string, four frames
        age_interval = '0;
        run_string(0, 10, "R3 arrival-order faults");
        run_string(1, 8,  "R4 recency faults");
        run_string(2, 8,  "R5 low-count faults");
        run_string(3, 10, "R6 high-count faults");

        // R7: saturation makes A tie with the others, arrival breaks the tie
        do_reset();
        for (int p = 1; p <= 4; p++) do_ref(p, 3);
        repeat (14) do_ref(2, 3);
        repeat (20) do_ref(1, 3);
        repeat (14) do_ref(3, 3);
        repeat (14) do_ref(4, 3);
        do_ref(9, 3);
        check(rsp_evict && rsp_frame == 0, "R7 saturated tie victim", int'(rsp_frame), 0);

        // R8: halving every 4 references
        do_reset();
        age_interval = AW'(4);
        for (int p = 1; p <= 4; p++) do_ref(p, 2);
        repeat (3) do_ref(1, 2);
        do_ref(2, 2);
        do_ref(5, 2);
        check(rsp_evict && rsp_frame == 1, "R8 victim after halving", int'(rsp_frame), 1);
        // R8: interval 0 disables halving
        do_reset();
        age_interval = '0;
        for (int p = 1; p <= 4; p++) do_ref(p, 2);
        repeat (3) do_ref(1, 2);
        do_ref(2, 2);
        do_ref(5, 2);
        check(rsp_evict && rsp_frame == 2, "R8 victim with halving off", int'(rsp_frame), 2);

        // random phases against the model
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            age_interval = AW'(ph == 0 ? 0 : (ph == 1 ? 1 : (ph == 2 ? 5 : 13)));
            for (int k = 0; k < 1500; k++) begin
                int pg, pol;
                pg  = (ph == 3) ? int'($urandom % 6) : int'($urandom % 8);
                pol = int'($urandom % 4);
                do_ref(pg, pol);
                if ($urandom % 8 == 0) begin
                    @(negedge clk);
                    check(rsp_valid == 1'b0, "R11 no response when idle", rsp_valid, 0);
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule